// File: doc/BRIEF.md
# Bit-6 Channel Swizzle Translator

This block matches CPU-side addressing of tiled surfaces to the memory channel interleave that the graphics engine uses. When memory runs dual-channel interleaved, the channel is picked from address bit 6 combined with several higher bits. A CPU that writes a tiled surface must apply the same combination, or its data lands on the wrong channel. The block has two parts. A mode selector decodes the memory-controller configuration into one swizzle mode for X-tiled surfaces and one for Y-tiled surfaces. An address translator then replaces bit 6 of each CPU address with bit 6 XORed with the higher bits that the mode names.

The configuration inputs are sampled only on a configure strobe. The chosen modes stay held until the next strobe or until reset. Some configurations cannot be decoded: the rank layout differs between the channels, the configuration read failed, or a code is reserved. These never report an unknown mode. They fall back to "no swizzle" and set a sticky pin-pages flag, which tells the memory manager to keep the backing pages from moving. A platform-class input can force a fixed setting that overrides the decoded configuration.

Top module: `swz_translator`

## Requirements
- R1: Reset clears both modes to code 0 (none) and clears pin_pages_o. With mode none, addr_o equals addr_i.
- R2: The mode codes are: 0 none, 1 bit 9, 2 bits 9+10, 3 bits 9+11, 4 bits 9+10+11, 5 bits 9+17, 6 bits 9+10+17. With platform class 0, channel mode 0 (single) or 1 (dual asymmetric) selects code 0 for both X and Y.
- R3: With platform class 0, channel mode 2 (dual interleaved) and xor_dis_i=1, X gets code 2 and Y gets code 1.
- R4: With platform class 0, channel mode 2, xor_dis_i=0 and xor_src17_i=0, X gets code 4 and Y gets code 3.
- R5: With platform class 0, channel mode 2, xor_dis_i=0 and xor_src17_i=1, X gets code 6 and Y gets code 5.
- R6: With platform class 0, any of rank_mismatch_i=1, read_fail_i=1 or channel mode 3 makes the configuration unknown. Platform class 3 is also unknown. An unknown configuration stores code 0 for both modes and sets pin_pages_o. pin_pages_o then stays set until reset, even after a later valid configuration.
- R7: Platform class 1 forces code 0 for both modes. Platform class 2 forces X code 2 and Y code 1. Both ignore the channel mode, the XOR inputs, rank_mismatch_i and read_fail_i, and neither sets pin_pages_o.
- R8: The configuration inputs only take effect in a cycle where cfg_strobe_i is high. At all other times the modes hold their value.
- R9: addr_o[6] equals addr_i[6] XORed with the address bits named by the mode that tile_y_i selects (0 selects the X mode, 1 the Y mode). Every other bit of addr_o equals the same bit of addr_i. With OUT_REG=1, addr_o appears one clock after addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_strobe_i | input | 1 | Capture the configuration inputs this cycle |
| plat_i | input | 2 | Platform class: 0 decode, 1 force none, 2 force base, 3 unknown |
| chan_mode_i | input | 2 | Channel addressing: 0 single, 1 dual asymmetric, 2 dual interleaved, 3 reserved |
| xor_dis_i | input | 1 | CPU channel XOR randomization disabled |
| xor_src17_i | input | 1 | CPU XOR source: 0 bit 11, 1 bit 17 |
| rank_mismatch_i | input | 1 | Rank layout differs between channels |
| read_fail_i | input | 1 | Configuration read returned all ones |
| addr_i | input | ADDR_W | CPU address to translate |
| tile_y_i | input | 1 | Tiling of the access: 0 X, 1 Y |
| addr_o | output | ADDR_W | Translated address |
| mode_x_o | output | 3 | Held mode code for X tiling |
| mode_y_o | output | 3 | Held mode code for Y tiling |
| pin_pages_o | output | 1 | Sticky flag: an unknown configuration was seen |

## Verification
A configuration driven with the strobe is captured at the next rising edge. mode_x_o, mode_y_o and pin_pages_o change right at that edge. A translated address is registered once, so addr_o is due on the first rising edge after addr_i is applied. The bench drives every stimulus on a falling edge and samples on the following falling edge, which is exactly one rising edge later. Each result is therefore read half a cycle after it becomes due and half a cycle before anything else can change it. For R8, the configuration inputs are changed with the strobe low, and the modes are read again after several edges.

// File: rtl/swz_pkg.sv
package swz_pkg;
  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_9        = 3'd1,
    SWZ_9_10     = 3'd2,
    SWZ_9_11     = 3'd3,
    SWZ_9_10_11  = 3'd4,
    SWZ_9_17     = 3'd5,
    SWZ_9_10_17  = 3'd6
  } swz_mode_e;

  typedef enum logic [1:0] {
    CH_SINGLE = 2'd0,
    CH_ASYM   = 2'd1,
    CH_ILV    = 2'd2,
    CH_RSVD   = 2'd3
  } chan_mode_e;

  typedef enum logic [1:0] {
    PLAT_DECODE = 2'd0,
    PLAT_NONE   = 2'd1,
    PLAT_BASE   = 2'd2,
    PLAT_RSVD   = 2'd3
  } plat_e;

  // bit 6 flip term for a mode, given the candidate high bits
  function automatic logic swz_flip(swz_mode_e m, logic b9, logic b10,
                                    logic b11, logic b17);
    logic f;
    f = 1'b0;
    unique case (m)
      SWZ_9:       f = b9;
      SWZ_9_10:    f = b9 ^ b10;
      SWZ_9_11:    f = b9 ^ b11;
      SWZ_9_10_11: f = b9 ^ b10 ^ b11;
      SWZ_9_17:    f = b9 ^ b17;
      SWZ_9_10_17: f = b9 ^ b10 ^ b17;
      default:     f = 1'b0;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/swz_mode_sel.sv
module swz_mode_sel
  import swz_pkg::*;
(
  input  logic [1:0] plat_i,
  input  logic [1:0] chan_mode_i,
  input  logic       xor_dis_i,
  input  logic       xor_src17_i,
  input  logic       rank_mismatch_i,
  input  logic       read_fail_i,
  output swz_mode_e  mode_x_o,
  output swz_mode_e  mode_y_o,
  output logic       unknown_o
);
  swz_mode_e dx, dy;
  logic      unk;

  always_comb begin
    dx  = SWZ_NONE;
    dy  = SWZ_NONE;
    unk = 1'b0;
    unique case (plat_e'(plat_i))
      PLAT_NONE: ;
      PLAT_BASE: begin
        dx = SWZ_9_10;
        dy = SWZ_9;
      end
      PLAT_RSVD: unk = 1'b1;
      default: begin
        unique case (chan_mode_e'(chan_mode_i))
          CH_SINGLE, CH_ASYM: ;
          CH_ILV: begin
            if (xor_dis_i) begin
              dx = SWZ_9_10;
              dy = SWZ_9;
            end else if (!xor_src17_i) begin
              dx = SWZ_9_10_11;
              dy = SWZ_9_11;
            end else begin
              dx = SWZ_9_10_17;
              dy = SWZ_9_17;
            end
          end
          default: unk = 1'b1;
        endcase
        if (rank_mismatch_i || read_fail_i) unk = 1'b1;
      end
    endcase
  end

  // unknown never escapes: report none instead
  assign mode_x_o  = unk ? SWZ_NONE : dx;
  assign mode_y_o  = unk ? SWZ_NONE : dy;
  assign unknown_o = unk;
endmodule

// File: rtl/swz_mode_reg.sv
module swz_mode_reg
  import swz_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cfg_strobe_i,
  input  swz_mode_e mode_x_i,
  input  swz_mode_e mode_y_i,
  input  logic      unknown_i,
  output swz_mode_e mode_x_o,
  output swz_mode_e mode_y_o,
  output logic      pin_pages_o
);
  swz_mode_e mx_q, my_q;
  logic      pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mx_q  <= SWZ_NONE;
      my_q  <= SWZ_NONE;
      pin_q <= 1'b0;
    end else if (cfg_strobe_i) begin
      mx_q  <= mode_x_i;
      my_q  <= mode_y_i;
      pin_q <= pin_q | unknown_i;
    end
  end

  assign mode_x_o    = mx_q;
  assign mode_y_o    = my_q;
  assign pin_pages_o = pin_q;

  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_strobe_i |=> ($stable(mx_q) && $stable(my_q)));

  assert_pin_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_q |=> pin_q);

  assert_unknown_none_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_strobe_i && unknown_i) |=> (pin_q && mx_q == SWZ_NONE && my_q == SWZ_NONE));

  assert_y_no_bit10_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(my_q inside {SWZ_9_10, SWZ_9_10_11, SWZ_9_10_17}));
endmodule

// File: rtl/swz_xlate.sv
module swz_xlate
  import swz_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  swz_mode_e         mode_x_i,
  input  swz_mode_e         mode_y_i,
  input  logic              tile_y_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int SWZ_BIT = 6;
  localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(1) << SWZ_BIT);

  swz_mode_e         mode_sel;
  logic              flip;
  logic [ADDR_W-1:0] addr_c;

  initial begin
    if (ADDR_W < 18) $error("ADDR_W must cover bit 17");
  end

  assign mode_sel = tile_y_i ? mode_y_i : mode_x_i;
  assign flip     = swz_flip(mode_sel, addr_i[9], addr_i[10], addr_i[11], addr_i[17]);

  always_comb begin
    addr_c          = addr_i;
    addr_c[SWZ_BIT] = addr_i[SWZ_BIT] ^ flip;
  end

  generate
    if (OUT_REG) begin : g_reg
      logic [ADDR_W-1:0] addr_q;
      logic              seen_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          addr_q <= '0;
          seen_q <= 1'b0;
        end else begin
          addr_q <= addr_c;
          seen_q <= 1'b1;
        end
      end
      assign addr_o = addr_q;

      assert_passthru_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_q |-> ((addr_o & KEEP_MASK) == ($past(addr_i) & KEEP_MASK)));

      assert_none_ident_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && $past(mode_sel) == SWZ_NONE) |-> (addr_o == $past(addr_i)));
    end else begin : g_comb
      assign addr_o = addr_c;

      always_comb begin
        if (rst_ni) begin
          assert_passthru_R9: assert ((addr_o & KEEP_MASK) == (addr_i & KEEP_MASK));
        end
      end
    end
  endgenerate
endmodule

// File: rtl/swz_translator.sv
module swz_translator
  import swz_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_strobe_i,
  input  logic [1:0]        plat_i,
  input  logic [1:0]        chan_mode_i,
  input  logic              xor_dis_i,
  input  logic              xor_src17_i,
  input  logic              rank_mismatch_i,
  input  logic              read_fail_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tile_y_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        mode_x_o,
  output logic [2:0]        mode_y_o,
  output logic              pin_pages_o
);
  swz_mode_e dec_x, dec_y, held_x, held_y;
  logic      dec_unk;

  swz_mode_sel i_sel (
    .plat_i          (plat_i),
    .chan_mode_i     (chan_mode_i),
    .xor_dis_i       (xor_dis_i),
    .xor_src17_i     (xor_src17_i),
    .rank_mismatch_i (rank_mismatch_i),
    .read_fail_i     (read_fail_i),
    .mode_x_o        (dec_x),
    .mode_y_o        (dec_y),
    .unknown_o       (dec_unk)
  );

  swz_mode_reg i_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_strobe_i (cfg_strobe_i),
    .mode_x_i     (dec_x),
    .mode_y_i     (dec_y),
    .unknown_i    (dec_unk),
    .mode_x_o     (held_x),
    .mode_y_o     (held_y),
    .pin_pages_o  (pin_pages_o)
  );

  swz_xlate #(.ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) i_xlate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_x_i (held_x),
    .mode_y_i (held_y),
    .tile_y_i (tile_y_i),
    .addr_i   (addr_i),
    .addr_o   (addr_o)
  );

  assign mode_x_o = held_x;
  assign mode_y_o = held_y;

  assert_forced_no_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_strobe_i && (plat_i == 2'd1 || plat_i == 2'd2) && !pin_pages_o) |=> !pin_pages_o);
endmodule

// File: tb/test_swz_translator.sv
`timescale 1ns/1ps
module test_swz_translator;
  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strobe = 1'b0;
  logic [1:0]    plat = 2'd0;
  logic [1:0]    chan = 2'd0;
  logic          xdis = 1'b0;
  logic          src17 = 1'b0;
  logic          rmis = 1'b0;
  logic          rfail = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ty = 1'b0;
  logic [AW-1:0] addr_out;
  logic [2:0]    mx, my;
  logic          pin;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  swz_translator #(.ADDR_W(AW), .OUT_REG(1'b1)) i_swz_translator (
    .clk_i(clk), .rst_ni(rst_n), .cfg_strobe_i(strobe), .plat_i(plat),
    .chan_mode_i(chan), .xor_dis_i(xdis), .xor_src17_i(src17),
    .rank_mismatch_i(rmis), .read_fail_i(rfail), .addr_i(addr),
    .tile_y_i(ty), .addr_o(addr_out), .mode_x_o(mx), .mode_y_o(my),
    .pin_pages_o(pin)
  );

  function automatic logic [AW-1:0] ref_addr(logic [AW-1:0] a, logic [2:0] code);
    logic f;
    logic [AW-1:0] r;
    f = 1'b0;
    if (code != 3'd0) f = a[9];
    if (code == 3'd2 || code == 3'd4 || code == 3'd6) f = f ^ a[10];
    if (code == 3'd3 || code == 3'd4) f = f ^ a[11];
    if (code == 3'd5 || code == 3'd6) f = f ^ a[17];
    r = a;
    r[6] = a[6] ^ f;
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic configure(logic [1:0] p, logic [1:0] c, logic xd, logic s17,
                           logic rm, logic rf);
    @(negedge clk);
    plat = p; chan = c; xdis = xd; src17 = s17; rmis = rm; rfail = rf;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic check_modes(string req, logic [2:0] ex, logic [2:0] ey, logic ep);
    chk(req, 64'(mx), 64'(ex));
    chk(req, 64'(my), 64'(ey));
    chk(req, 64'(pin), 64'(ep));
  endtask

  // one address through X and Y, result due one rising edge later
  task automatic check_xlate(string req, logic [AW-1:0] a, logic [2:0] cx, logic [2:0] cy);
    @(negedge clk);
    addr = a; ty = 1'b0;
    @(negedge clk);
    chk(req, 64'(addr_out), 64'(ref_addr(a, cx)));
    ty = 1'b1;
    @(negedge clk);
    chk(req, 64'(addr_out), 64'(ref_addr(a, cy)));
  endtask

  task automatic sweep(string req, logic [2:0] cx, logic [2:0] cy);
    logic [AW-1:0] pats [8];
    pats[0] = 40'h00_0000_0200; pats[1] = 40'h00_0000_0400;
    pats[2] = 40'h00_0000_0800; pats[3] = 40'h00_0002_0000;
    pats[4] = 40'h00_0002_0E40; pats[5] = 40'hA5_5A3C_F7FF;
    pats[6] = 40'hFF_FFFF_FFBF; pats[7] = 40'h12_3456_0640;
    for (int i = 0; i < 8; i++) check_xlate(req, pats[i], cx, cy);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset();
    check_modes("R1", 3'd0, 3'd0, 1'b0);
    sweep("R1", 3'd0, 3'd0);
  endtask

  task automatic t_noswizzle;
    configure(2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    configure(2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    check_modes("R2 single", 3'd0, 3'd0, 1'b0);
    configure(2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    configure(2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    check_modes("R2 asym", 3'd0, 3'd0, 1'b0);
    sweep("R2", 3'd0, 3'd0);
  endtask

  task automatic t_base;
    configure(2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    check_modes("R3", 3'd2, 3'd1, 1'b0);
    sweep("R3 R9", 3'd2, 3'd1);
  endtask

  task automatic t_bit11;
    configure(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    check_modes("R4", 3'd4, 3'd3, 1'b0);
    sweep("R4 R9", 3'd4, 3'd3);
  endtask

  task automatic t_bit17;
    configure(2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
    check_modes("R5", 3'd6, 3'd5, 1'b0);
    sweep("R5 R9", 3'd6, 3'd5);
  endtask

  task automatic t_hold;
    configure(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    plat = 2'd3; chan = 2'd3; xdis = 1'b1; rmis = 1'b1; rfail = 1'b1;
    repeat (4) @(negedge clk);
    check_modes("R8", 3'd4, 3'd3, 1'b0);
    check_xlate("R8", 40'h00_0000_0800, 3'd4, 3'd3);
  endtask

  task automatic t_forced;
    configure(2'd1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1);
    check_modes("R7 none", 3'd0, 3'd0, 1'b0);
    configure(2'd2, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1);
    check_modes("R7 base", 3'd2, 3'd1, 1'b0);
    sweep("R7", 3'd2, 3'd1);
  endtask

  task automatic t_unknown;
    configure(2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0);
    check_modes("R6 rank", 3'd0, 3'd0, 1'b1);
    sweep("R6", 3'd0, 3'd0);
    configure(2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
    check_modes("R6 sticky", 3'd6, 3'd5, 1'b1);
    do_reset();
    configure(2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1);
    check_modes("R6 readfail", 3'd0, 3'd0, 1'b1);
    do_reset();
    configure(2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    check_modes("R6 chan3", 3'd0, 3'd0, 1'b1);
    do_reset();
    configure(2'd3, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    check_modes("R6 plat3", 3'd0, 3'd0, 1'b1);
    do_reset();
    check_modes("R1 after pin", 3'd0, 3'd0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_noswizzle();
    t_base();
    t_bit11();
    t_bit17();
    t_hold();
    t_forced();
    t_unknown();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule